// File: doc/BRIEF.md
# Real-Time Clock Time-Base Divider and Rate Selector

This block divides the oscillator clock of a real-time clock down to a one-second update tick, and it brings out a choice of intermediate divider stages. Three oscillator frequencies are supported. A two-bit time-base code tells the chain how many of its low stages to skip: 4.194304 MHz uses all 22 stages, 1.048576 MHz skips 2 and 32.768 kHz skips 7. In every case the last stage completes one full period per second.

A four-bit rate code picks one of fifteen stages. That stage drives a square-wave pin, gated by an enable, and a periodic tick pulse. Code 15 gives a 500 ms period, and each lower code halves the period. A hold input clears the chain. When the hold is released with a valid time base, the first update tick comes half a second later and the next ticks come once a second.

All inputs are plain control levels sampled on the oscillator clock, so the block has no data stream and no valid/ready handshake.

Top module: `rtc_timebase`

## Requirements
- R1: While `rst_n` is low, the chain is cleared and `sqw`, `pi_tick` and `sec_tick` are low.
- R2: While `div_hold` is 1, or while `tb_sel` is 2'b11, the chain is held at zero on every clock edge and neither tick pulses.
- R3: With `tb_sel` 2'b00, 2'b01 or 2'b10, each clock edge advances the 22-stage chain by 2^0, 2^2 or 2^7 respectively, counted at stage 0.
- R4: `sec_tick` is high for exactly one cycle after each clock edge on which stage 21 goes from 0 to 1. With a valid time base, the first such edge is 2^21/2^skip edges after release from hold, and later ones follow every 2^22/2^skip edges.
- R5: A rate code r from 1 to 15 selects stage r+5. The selected stage therefore has a period of 2^(r+6) chain counts, and code 15 gives 500 ms.
- R6: `sqw` equals the selected stage whenever `sqw_en` is 1 and the rate code is nonzero. `sqw` is low whenever `sqw_en` is 0.
- R7: Rate code 4'b0000 keeps both `sqw` and `pi_tick` low.
- R8: `pi_tick` is high for one cycle after each clock edge on which the selected stage goes from 0 to 1, and `sqw_en` does not affect it.
- R9: A rate code whose stage lies among the skipped stages gives a constant low `sqw` and no `pi_tick`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_sel | input | 2 | Time-base code: 00 = 4.194304 MHz, 01 = 1.048576 MHz, 10 = 32.768 kHz, 11 = stop |
| rate_sel | input | 4 | Rate code, 0 = off, 1 to 15 = stage r+5 |
| div_hold | input | 1 | Clears and holds the chain while 1 |
| sqw_en | input | 1 | Square-wave output enable |
| sqw | output | 1 | Square-wave output |
| pi_tick | output | 1 | Periodic tick, one cycle wide |
| sec_tick | output | 1 | One-second update tick, one cycle wide |

## Verification
The 32.768 kHz base is released from hold and run for more than a second. This measures the half-second delay to the first update tick and the one-second spacing of the next, which separates a correct skip count and final-stage pick from an off-by-one. A directed run at 4.194304 MHz with code 3 measures the spacing of the periodic tick. Random segments then mix rate codes, enables, holds and time bases, including codes that point into skipped stages. Every cycle is compared with a bench model of the chain, which shows up a wrong tap, gating or edge detection.

// File: rtl/rtc_tbase_pkg.sv
package rtc_tbase_pkg;

  typedef enum logic [1:0] {
    TB_FAST = 2'b00,
    TB_MID  = 2'b01,
    TB_SLOW = 2'b10,
    TB_STOP = 2'b11
  } tbase_e;

  localparam int unsigned SKIP_W    = 5;
  localparam int unsigned SKIP_FAST = 0;
  localparam int unsigned SKIP_MID  = 2;
  localparam int unsigned SKIP_SLOW = 7;

  // Number of low chain stages bypassed for a time-base code.
  function automatic logic [SKIP_W-1:0] skip_of(input logic [1:0] code);
    case (code)
      TB_FAST: skip_of = SKIP_W'(SKIP_FAST);
      TB_MID:  skip_of = SKIP_W'(SKIP_MID);
      TB_SLOW: skip_of = SKIP_W'(SKIP_SLOW);
      default: skip_of = '0;
    endcase
  endfunction

endpackage

// File: rtl/rtc_div_chain.sv
module rtc_div_chain #(
  parameter int unsigned STAGES = 22,
  parameter int unsigned SKIP_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [SKIP_W-1:0] skip,
  output logic [STAGES-1:0] chain_q,
  output logic [STAGES-1:0] chain_d,
  output logic              sec_tick
);

  localparam int unsigned TOP = STAGES - 1;

  logic [STAGES-1:0] step;

  always_comb begin
    step    = {{(STAGES-1){1'b0}}, 1'b1} << skip;
    chain_d = run ? (chain_q + step) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q  <= '0;
      sec_tick <= 1'b0;
    end else begin
      chain_q  <= chain_d;
      sec_tick <= chain_d[TOP] & ~chain_q[TOP];
    end
  end

endmodule

// File: rtl/rtc_tap_select.sv
module rtc_tap_select #(
  parameter int unsigned STAGES  = 22,
  parameter int unsigned RATE_W  = 4,
  parameter int unsigned TAP_OFS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAGES-1:0] chain_q,
  input  logic [STAGES-1:0] chain_d,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              sqw_en,
  output logic              sqw,
  output logic              pi_tick
);

  localparam int unsigned NCODES = 1 << RATE_W;

  logic [NCODES-1:0] tap_now;
  logic [NCODES-1:0] tap_nxt;

  assign tap_now[0] = 1'b0;
  assign tap_nxt[0] = 1'b0;

  for (genvar g = 1; g < NCODES; g++) begin : g_tap
    if (g + TAP_OFS < STAGES) begin : g_live
      assign tap_now[g] = chain_q[g + TAP_OFS];
      assign tap_nxt[g] = chain_d[g + TAP_OFS];
    end else begin : g_dead
      assign tap_now[g] = 1'b0;
      assign tap_nxt[g] = 1'b0;
    end
  end

  assign sqw = sqw_en & tap_now[rate_sel];

  always_ff @(posedge clk) begin
    if (!rst_n) pi_tick <= 1'b0;
    else        pi_tick <= tap_nxt[rate_sel] & ~tap_now[rate_sel];
  end

endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase
  import rtc_tbase_pkg::*;
#(
  parameter int unsigned STAGES  = 22,
  parameter int unsigned RATE_W  = 4,
  parameter int unsigned TAP_OFS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        tb_sel,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              div_hold,
  input  logic              sqw_en,
  output logic              sqw,
  output logic              pi_tick,
  output logic              sec_tick
);

  logic              run;
  logic [SKIP_W-1:0] skip;
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  assign run  = ~div_hold & (tb_sel != TB_STOP);
  assign skip = skip_of(tb_sel);

  rtc_div_chain #(.STAGES(STAGES), .SKIP_W(SKIP_W)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .skip     (skip),
    .chain_q  (chain_q),
    .chain_d  (chain_d),
    .sec_tick (sec_tick)
  );

  rtc_tap_select #(.STAGES(STAGES), .RATE_W(RATE_W), .TAP_OFS(TAP_OFS)) u_tap (
    .clk      (clk),
    .rst_n    (rst_n),
    .chain_q  (chain_q),
    .chain_d  (chain_d),
    .rate_sel (rate_sel),
    .sqw_en   (sqw_en),
    .sqw      (sqw),
    .pi_tick  (pi_tick)
  );

endmodule

// File: rtl/rtc_timebase_chk.sv
module rtc_timebase_chk
  import rtc_tbase_pkg::*;
#(
  parameter int unsigned STAGES = 22,
  parameter int unsigned RATE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        tb_sel,
  input logic [RATE_W-1:0] rate_sel,
  input logic              div_hold,
  input logic              sqw_en,
  input logic              sqw,
  input logic              pi_tick,
  input logic              sec_tick,
  input logic [STAGES-1:0] chain
);

  localparam int unsigned TOP = STAGES - 1;

  // R2
  p_hold_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (div_hold || tb_sel == TB_STOP) |=> (chain == '0 && !sec_tick));

  // R3
  p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!div_hold && tb_sel != TB_STOP) |=>
      (chain == $past(chain) + ({{(STAGES-1){1'b0}}, 1'b1} << skip_of($past(tb_sel)))));

  // R4
  p_sec_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> (chain[TOP] && !$past(chain[TOP])));

  // R6
  p_sqw_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sqw_en |-> !sqw);

  // R7
  p_rate_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == '0) |=> !pi_tick);

  // R8
  p_pi_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pi_tick |=> !pi_tick);

endmodule

bind rtc_timebase rtc_timebase_chk #(.STAGES(STAGES), .RATE_W(RATE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tb_sel   (tb_sel),
  .rate_sel (rate_sel),
  .div_hold (div_hold),
  .sqw_en   (sqw_en),
  .sqw      (sqw),
  .pi_tick  (pi_tick),
  .sec_tick (sec_tick),
  .chain    (chain_q)
);

// File: tb/rtc_timebase_tb.sv
`timescale 1ns/1ps
module rtc_timebase_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] tb_sel = 2'b10;
  logic [3:0] rate_sel = 4'd0;
  logic       div_hold = 1'b1;
  logic       sqw_en = 1'b0;
  logic       sqw, pi_tick, sec_tick;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  rtc_timebase u_dut (
    .clk(clk), .rst_n(rst_n), .tb_sel(tb_sel), .rate_sel(rate_sel),
    .div_hold(div_hold), .sqw_en(sqw_en),
    .sqw(sqw), .pi_tick(pi_tick), .sec_tick(sec_tick)
  );

  function automatic int skip_f(input logic [1:0] c);
    case (c)
      2'b00: return 0;
      2'b01: return 2;
      2'b10: return 7;
      default: return 0;
    endcase
  endfunction

  function automatic bit stage_f(input logic [21:0] v, input logic [3:0] r);
    if (r == 0) return 1'b0;
    return v[int'(r) + 5];
  endfunction

  // Bench model of the chain, built from R1 to R4 and R8
  logic [21:0] m_cnt = '0;
  bit          m_pi = 1'b0, m_sec = 1'b0;

  always @(posedge clk) begin
    logic [21:0] nx;
    if (!rst_n || div_hold || tb_sel == 2'b11) nx = '0;
    else nx = m_cnt + (22'd1 << skip_f(tb_sel));
    m_pi  <= rst_n && stage_f(nx, rate_sel) && !stage_f(m_cnt, rate_sel);
    m_sec <= rst_n && nx[21] && !m_cnt[21];
    m_cnt <= nx;
  end

  task automatic chk(input string req, input string what, input bit act, input bit exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      if (n_bad < 30) $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chk_int(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One clock, then compare all outputs with the model
  task automatic step();
    string tag;
    bit    e_sqw;
    @(negedge clk);
    e_sqw = sqw_en && stage_f(m_cnt, rate_sel);
    if (!rst_n)                              tag = "R1";
    else if (div_hold || tb_sel == 2'b11)    tag = "R2";
    else if (rate_sel == 0)                  tag = "R7";
    else if (int'(rate_sel) + 5 < skip_f(tb_sel)) tag = "R9";
    else                                     tag = "R6";
    chk(tag, "sqw", sqw, e_sqw);
    chk(tag == "R6" ? "R8" : tag, "pi_tick", pi_tick, m_pi);
    chk(rst_n ? "R4" : "R1", "sec_tick", sec_tick, m_sec);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int first_sec = -1, second_sec = -1;
    int p0 = -1, p1 = -1;
    void'($urandom(32'h5eed_71c3));

    // R1: reset state
    rate_sel = 4'd15; sqw_en = 1'b1; div_hold = 1'b0;
    repeat (4) step();
    chk("R1", "sqw in reset", sqw, 1'b0);
    chk("R1", "pi_tick in reset", pi_tick, 1'b0);
    @(negedge clk); rst_n = 1'b1; div_hold = 1'b1;
    repeat (3) step();

    // R3/R4: slow base, half second to first tick, then one second
    tb_sel = 2'b10; div_hold = 1'b0;
    for (int k = 1; k <= 49160; k++) begin
      step();
      if (sec_tick) begin
        if (first_sec < 0) first_sec = k;
        else if (second_sec < 0) second_sec = k;
      end
    end
    chk_int("R3", "first sec_tick edge (slow base)", first_sec, 16384);
    chk_int("R4", "sec_tick spacing (slow base)", second_sec - first_sec, 32768);

    // R5: fast base, code 3 -> stage 8, rising edge every 512 clocks
    div_hold = 1'b1; step(); tb_sel = 2'b00; rate_sel = 4'd3; step();
    div_hold = 1'b0;
    for (int k = 1; k <= 1600; k++) begin
      step();
      if (pi_tick) begin
        if (p0 < 0) p0 = k; else if (p1 < 0) p1 = k;
      end
    end
    chk_int("R5", "pi_tick spacing code 3", p1 - p0, 512);
    chk_int("R5", "first pi_tick code 3", p0, 256);

    // R7: rate off, R2: stop code
    rate_sel = 4'd0;
    repeat (600) step();
    tb_sel = 2'b11; rate_sel = 4'd1;
    repeat (50) step();
    chk("R2", "sqw with stopped base", sqw, 1'b0);

    // R9: slow base, code 1 selects skipped stage 6
    div_hold = 1'b1; step(); tb_sel = 2'b10; div_hold = 1'b0; rate_sel = 4'd1; sqw_en = 1'b1;
    repeat (300) step();

    // Random segments
    for (int s = 0; s < 60; s++) begin
      int len = 50 + int'($urandom_range(0, 700));
      rate_sel = 4'($urandom_range(0, 15));
      sqw_en   = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 5) == 0) begin
        div_hold = 1'b1; step();
        tb_sel = 2'($urandom_range(0, 3));
        step();
        div_hold = 1'($urandom_range(0, 7) == 0);
      end
      for (int k = 0; k < len; k++) step();
    end
    finish_run();
  end

endmodule